// File: doc/BRIEF.md
# SPI Master Transaction Sequencer

This block sequences the slave-select side of an SPI master. After a start request it drives the chosen select lines to their active levels and waits a programmable lead time. It then enables the serial shift engine and counts the completed characters that the engine reports. Once the last character is done it waits a programmable trail time before it releases the lines, or keeps them asserted when hold-select is set. Bit shifting and serial clock generation happen outside this block. The sequencer only receives a one-cycle strobe from the shift engine as each character finishes.

When a transaction ends and the transmit FIFO still holds data, the sequencer waits a programmable gap and then starts another transaction without a new start request. When the FIFO is empty it stops, drops busy and pulses done. The lead, trail and gap delays are each counted in system clocks, and a programmed value of zero stands for the full range of the field (256 with 8-bit fields). Clearing the enable input aborts at once.

Top module: `spim_txn_seq`

## Requirements
- R1: Under reset, busy, shift_en, done, sel_rise and sel_fall are 0 and every sel_out line sits at its inactive level, which is the inverse of its sel_pol bit.
- R2: A start pulse sampled while enable is high and the block is idle sets busy and activates the select lines on the same clock edge.
- R3: shift_en rises exactly L clocks after the select lines activate, where L is pre_dly and a value of 0 means 2^DLY_W.
- R4: shift_en stays high until the char_done strobe that completes the programmed character count, and it falls on the edge that samples that strobe. A char_count of 0 means 2^CNT_W characters.
- R5: Exactly T clocks after shift_en falls, where T is post_dly and 0 means 2^DLY_W, the select lines return to inactive unless hold_sel is set.
- R6: If tx_empty is high when the trail delay ends, busy clears on that edge and done pulses high for exactly one clock.
- R7: If tx_empty is low when the trail delay ends, busy stays high and done stays low. The block waits G clocks, where G is gap_dly and 0 means 2^DLY_W. It then activates the select lines again and runs a new lead delay and character count.
- R8: With hold_sel set, the lines stay active at the end of a transaction and no sel_fall pulse occurs. A following start does not re-pulse sel_rise and keeps the line set that was already captured.
- R9: sel_rise and sel_fall are one clock wide, never high together, and occur on the edge on which the select lines switch between inactive and active.
- R10: Driving enable low aborts on the next edge. busy and shift_en go to 0, the lines go inactive, sel_fall pulses if the lines were active, and done stays 0.
- R11: A start pulse is ignored while enable is low or while busy is high.
- R12: A line whose sel_mask bit is 1 drives its sel_pol bit when it is active (1 = active high), and several lines may be active at the same time. Lines whose sel_mask bit is 0 stay at their inactive level. The mask is captured when the lines go from inactive to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low aborts and idles |
| start | input | 1 | Start request pulse |
| tx_empty | input | 1 | Transmit FIFO empty status |
| char_count | input | CNT_W | Characters per transaction (0 = 2^CNT_W) |
| pre_dly | input | DLY_W | Lead delay, select to first shift (0 = 2^DLY_W) |
| post_dly | input | DLY_W | Trail delay, last shift to release (0 = 2^DLY_W) |
| gap_dly | input | DLY_W | Gap between transactions (0 = 2^DLY_W) |
| sel_mask | input | NUM_SEL | Lines to activate, one bit per line |
| sel_pol | input | NUM_SEL | Active level per line, 1 = high |
| hold_sel | input | 1 | Keep lines active at transaction end |
| char_done | input | 1 | Strobe from shift engine, one per character |
| sel_out | output | NUM_SEL | Select line pins |
| shift_en | output | 1 | Enable to the serial shift engine |
| busy | output | 1 | Transaction sequence in progress |
| done | output | 1 | One-clock pulse when the sequence finishes |
| sel_rise | output | 1 | One-clock pulse when the lines become active |
| sel_fall | output | 1 | One-clock pulse when the lines become inactive |

## Verification
The bench builds the block with CNT_W=6, DLY_W=8 and NUM_SEL=4. The narrow count makes the zero-means-full-range case reachable as a 64-character transaction. The 8-bit delays allow the 256-clock encodings of lead, trail and gap to be measured directly. Four lines with mixed polarity and multi-bit masks show that each line's level follows its own bit. Chained auto-restart groups show that the mask captured by a held select carries over to the next group.

// File: rtl/spim_seq_pkg.sv
package spim_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_SHIFT,
    SQ_TRAIL,
    SQ_GAP
  } sq_state_t;
endpackage

// File: rtl/spim_dly_timer.sv
module spim_dly_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [DLY_W-1:0] val,
  output logic             expire
);
  localparam int CW = DLY_W + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << DLY_W;

  logic [CW-1:0] cnt;

  // A zero field encodes the full range.
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (load)
      cnt <= (val == '0) ? FULL : {1'b0, val};
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  // Fires in the last cycle of the window, so the owner switches state after exactly N cycles.
  assign expire = (cnt == CW'(1));

  a_r3_timer_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  a_r5_load_arms: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (cnt != '0));
endmodule

// File: rtl/spim_char_ctr.sv
module spim_char_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  input  logic             dec,
  output logic             last
);
  localparam int RW = CNT_W + 1;
  localparam logic [RW-1:0] FULL = RW'(1) << CNT_W;

  logic [RW-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst || clr)
      rem <= '0;
    else if (load)
      rem <= (val == '0) ? FULL : {1'b0, val};
    else if (dec && rem != '0)
      rem <= rem - 1'b1;
  end

  assign last = (rem == RW'(1));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst || clr)
    dec |-> (rem != '0));
endmodule

// File: rtl/spim_sel_drv.sv
module spim_sel_drv #(
  parameter int NSEL = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act_nxt,
  input  logic            mask_load,
  input  logic [NSEL-1:0] mask_in,
  input  logic [NSEL-1:0] pol,
  output logic [NSEL-1:0] sel_out,
  output logic            act,
  output logic            rise,
  output logic            fall
);
  logic [NSEL-1:0] mask_q;
  logic [NSEL-1:0] mask_nxt;
  logic            act_q;
  logic            rise_q;
  logic            fall_q;

  assign mask_nxt = mask_load ? mask_in : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      mask_q <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      act_q  <= act_nxt;
      mask_q <= mask_nxt;
      rise_q <= act_nxt & ~act_q;
      fall_q <= ~act_nxt & act_q;
    end
  end

  for (genvar i = 0; i < NSEL; i++) begin : g_line
    logic pin_q;
    // Active level equals the polarity bit, inactive level is its inverse.
    always_ff @(posedge clk) begin
      if (rst)
        pin_q <= ~pol[i];
      else
        pin_q <= ~(pol[i] ^ (act_nxt & mask_nxt[i]));
    end
    assign sel_out[i] = pin_q;
  end

  assign act  = act_q;
  assign rise = rise_q;
  assign fall = fall_q;

  a_r9_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rise_q && fall_q));
  a_r9_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise_q |=> !rise_q);
  a_r9_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall_q |=> !fall_q);
  a_r9_rise_tracks_act: assert property (@(posedge clk) disable iff (rst)
    rise_q |-> act_q);
endmodule

// File: rtl/spim_txn_seq.sv
module spim_txn_seq
  import spim_seq_pkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int CNT_W   = 16,
  parameter int DLY_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               start,
  input  logic               tx_empty,
  input  logic [CNT_W-1:0]   char_count,
  input  logic [DLY_W-1:0]   pre_dly,
  input  logic [DLY_W-1:0]   post_dly,
  input  logic [DLY_W-1:0]   gap_dly,
  input  logic [NUM_SEL-1:0] sel_mask,
  input  logic [NUM_SEL-1:0] sel_pol,
  input  logic               hold_sel,
  input  logic               char_done,
  output logic [NUM_SEL-1:0] sel_out,
  output logic               shift_en,
  output logic               busy,
  output logic               done,
  output logic               sel_rise,
  output logic               sel_fall
);
  sq_state_t        st, st_n;
  logic             busy_q, busy_n;
  logic             shift_q, shift_n;
  logic             done_q, done_n;
  logic             act_q, act_n;
  logic             t_load, t_exp;
  logic [DLY_W-1:0] t_val;
  logic             c_load, c_dec, c_last;
  logic             m_load;

  spim_dly_timer #(.DLY_W(DLY_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (~enable),
    .load   (t_load),
    .val    (t_val),
    .expire (t_exp)
  );

  assign c_dec = enable && (st == SQ_SHIFT) && char_done;

  spim_char_ctr #(.CNT_W(CNT_W)) u_chars (
    .clk  (clk),
    .rst  (rst),
    .clr  (~enable),
    .load (c_load),
    .val  (char_count),
    .dec  (c_dec),
    .last (c_last)
  );

  spim_sel_drv #(.NSEL(NUM_SEL)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .act_nxt   (act_n),
    .mask_load (m_load),
    .mask_in   (sel_mask),
    .pol       (sel_pol),
    .sel_out   (sel_out),
    .act       (act_q),
    .rise      (sel_rise),
    .fall      (sel_fall)
  );

  always_comb begin
    st_n    = st;
    busy_n  = busy_q;
    shift_n = shift_q;
    done_n  = 1'b0;
    act_n   = act_q;
    t_load  = 1'b0;
    t_val   = pre_dly;
    c_load  = 1'b0;
    m_load  = 1'b0;
    if (!enable) begin
      st_n    = SQ_IDLE;
      busy_n  = 1'b0;
      shift_n = 1'b0;
      act_n   = 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) begin
          st_n   = SQ_LEAD;
          busy_n = 1'b1;
          act_n  = 1'b1;
          m_load = !act_q;
          t_load = 1'b1;
          t_val  = pre_dly;
          c_load = 1'b1;
        end
        SQ_LEAD: if (t_exp) begin
          st_n    = SQ_SHIFT;
          shift_n = 1'b1;
        end
        SQ_SHIFT: if (char_done && c_last) begin
          st_n    = SQ_TRAIL;
          shift_n = 1'b0;
          t_load  = 1'b1;
          t_val   = post_dly;
        end
        SQ_TRAIL: if (t_exp) begin
          if (!hold_sel) act_n = 1'b0;
          if (tx_empty) begin
            st_n   = SQ_IDLE;
            busy_n = 1'b0;
            done_n = 1'b1;
          end else begin
            st_n   = SQ_GAP;
            t_load = 1'b1;
            t_val  = gap_dly;
          end
        end
        SQ_GAP: if (t_exp) begin
          st_n   = SQ_LEAD;
          act_n  = 1'b1;
          m_load = !act_q;
          t_load = 1'b1;
          t_val  = pre_dly;
          c_load = 1'b1;
        end
        default: st_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      busy_q  <= 1'b0;
      shift_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st      <= st_n;
      busy_q  <= busy_n;
      shift_q <= shift_n;
      done_q  <= done_n;
    end
  end

  assign busy     = busy_q;
  assign shift_en = shift_q;
  assign done     = done_q;

  a_r4_shift_within_busy: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> busy);
  a_r3_shift_follows_lead: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_en) |-> ($past(st) == SQ_LEAD));
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_abort_idles: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!busy && !shift_en && !done));
  a_r2_rise_while_busy: assert property (@(posedge clk) disable iff (rst)
    sel_rise |-> busy);
endmodule

// File: tb/spim_txn_seq_test.sv
module spim_txn_seq_test;
  localparam int CLK_P = 10;
  localparam int NSEL  = 4;
  localparam int CW    = 6;
  localparam int DW    = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            enable = 1'b0;
  logic            start = 1'b0;
  logic            tx_empty = 1'b1;
  logic [CW-1:0]   char_count = '0;
  logic [DW-1:0]   pre_dly = '0, post_dly = '0, gap_dly = '0;
  logic [NSEL-1:0] sel_mask = '0;
  logic [NSEL-1:0] sel_pol = 4'b0101;
  logic            hold_sel = 1'b0;
  logic            char_done = 1'b0;
  logic [NSEL-1:0] sel_out;
  logic            shift_en, busy, done, sel_rise, sel_fall;

  spim_txn_seq #(.NUM_SEL(NSEL), .CNT_W(CW), .DLY_W(DW)) uut (
    .clk(clk), .rst(rst), .enable(enable), .start(start), .tx_empty(tx_empty),
    .char_count(char_count), .pre_dly(pre_dly), .post_dly(post_dly),
    .gap_dly(gap_dly), .sel_mask(sel_mask), .sel_pol(sel_pol),
    .hold_sel(hold_sel), .char_done(char_done), .sel_out(sel_out),
    .shift_en(shift_en), .busy(busy), .done(done),
    .sel_rise(sel_rise), .sel_fall(sel_fall)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  int n_rise = 0, n_fall = 0, n_done = 0;
  bit held = 1'b0;
  logic [NSEL-1:0] held_mask = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    if (sel_rise) n_rise++;
    if (sel_fall) n_fall++;
    if (done) n_done++;
  endtask

  function automatic logic [NSEL-1:0] exp_sel(logic [NSEL-1:0] m, logic [NSEL-1:0] p, bit a);
    return ~(p ^ (a ? m : '0));
  endfunction
  function automatic int span(int v);
    return (v == 0) ? (1 << DW) : v;
  endfunction
  function automatic int nchars(int v);
    return (v == 0) ? (1 << CW) : v;
  endfunction

  task automatic run_group(input int pre, input int post, input int gap, input int cnt,
                           input logic [NSEL-1:0] mask, input logic [NSEL-1:0] pol,
                           input bit hold, input int ntx, input bit spur);
    int r0, f0, d0, c, er, ef;
    bit ok;
    logic [NSEL-1:0] cur;
    r0 = n_rise; f0 = n_fall; d0 = n_done;
    pre_dly = pre[DW-1:0]; post_dly = post[DW-1:0]; gap_dly = gap[DW-1:0];
    char_count = cnt[CW-1:0]; sel_mask = mask; sel_pol = pol; hold_sel = hold;
    tx_empty = (ntx == 1);
    cur = held ? held_mask : mask;
    er = (held ? 0 : 1) + (hold ? 0 : ntx - 1);
    ef = hold ? 0 : ntx;
    start = 1'b1; tick; start = 1'b0;
    chk(busy == 1'b1, "R2 busy on start", busy, 1);
    chk(sel_out == exp_sel(cur, pol, 1'b1), "R12 active levels", sel_out, exp_sel(cur, pol, 1'b1));
    for (int i = 0; i < ntx; i++) begin
      tx_empty = (i == ntx - 1);
      c = 0;
      do begin tick; c++; end while (!shift_en && c < 300);
      chk(c == span(pre), "R3 lead delay", c, span(pre));
      ok = 1'b1;
      for (int k = 0; k < nchars(cnt); k++) begin
        int g;
        g = $urandom_range(0, 2);
        repeat (g) begin tick; if (!shift_en) ok = 1'b0; end
        char_done = 1'b1;
        if (spur && k == 0) start = 1'b1;  // R11: start while busy
        tick;
        char_done = 1'b0; start = 1'b0;
        if (k < nchars(cnt) - 1 && !shift_en) ok = 1'b0;
      end
      chk(ok, "R4 shift held until final char", ok, 1);
      chk(!shift_en, "R4 shift drops after final char", shift_en, 0);
      ok = 1'b1;
      repeat (span(post) - 1) begin
        tick;
        if (sel_fall || done || sel_out != exp_sel(cur, pol, 1'b1)) ok = 1'b0;
      end
      tick;
      chk(ok, "R5 select kept through trail", ok, 1);
      if (!hold)
        chk(sel_fall && sel_out == exp_sel(cur, pol, 1'b0), "R5 release after trail",
            sel_out, exp_sel(cur, pol, 1'b0));
      else
        chk(!sel_fall && sel_out == exp_sel(cur, pol, 1'b1), "R8 select held",
            sel_out, exp_sel(cur, pol, 1'b1));
      if (i == ntx - 1) begin
        chk(done && !busy, "R6 done pulse and busy clear", {done, busy}, 2);
      end else begin
        chk(!done && busy, "R7 no done before restart", {done, busy}, 1);
        repeat (span(gap)) tick;
        if (!hold) cur = mask;
        chk(busy && sel_out == exp_sel(cur, pol, 1'b1), "R7 reassert after gap",
            sel_out, exp_sel(cur, pol, 1'b1));
      end
    end
    tick;
    chk(!done && n_done - d0 == 1, "R6 single done pulse", n_done - d0, 1);
    chk(n_rise - r0 == er, "R9 rise pulse count", n_rise - r0, er);
    chk(n_fall - f0 == ef, "R9 fall pulse count", n_fall - f0, ef);
    held = hold;
    held_mask = cur;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sel_out == 4'b1010, "R1 idle levels", sel_out, 4'b1010);
    chk(!busy && !shift_en && !done && !sel_rise && !sel_fall, "R1 outputs low",
        {busy, shift_en, done, sel_rise, sel_fall}, 0);
    rst = 1'b0;
    tick;
    // R11: start while disabled
    start = 1'b1; tick; start = 1'b0; tick;
    chk(!busy && sel_out == 4'b1010 && n_rise == 0, "R11 start ignored when disabled", busy, 0);
    enable = 1'b1; tick;
    // Directed cases
    run_group(3, 2, 4, 2, 4'b0001, 4'b0000, 1'b0, 1, 1'b0);
    run_group(5, 3, 2, 3, 4'b1011, 4'b0110, 1'b0, 3, 1'b1);   // R12 multi-line, R7
    run_group(0, 0, 0, 1, 4'b0100, 4'b1111, 1'b0, 2, 1'b0);   // 256 encodings
    run_group(2, 2, 2, 0, 4'b0010, 4'b0000, 1'b0, 1, 1'b0);   // R4 count zero
    run_group(4, 3, 3, 2, 4'b0011, 4'b0001, 1'b1, 2, 1'b0);   // R8 hold
    run_group(2, 5, 2, 1, 4'b1100, 4'b0001, 1'b0, 2, 1'b0);   // R8 held mask kept
    chk(sel_out == exp_sel(4'b0000, 4'b0001, 1'b0), "R5 idle after release", sel_out, 4'b1110);
    // R10: abort while active
    pre_dly = 8'd60; sel_mask = 4'b1001; sel_pol = 4'b1000; hold_sel = 1'b0;
    start = 1'b1; tick; start = 1'b0;
    repeat (5) tick;
    enable = 1'b0; tick;
    chk(!busy && !shift_en && !done && sel_fall && sel_out == 4'b0111,
        "R10 abort", sel_out, 4'b0111);
    enable = 1'b1; held = 1'b0; tick;
    // Random groups
    for (int r = 0; r < 10; r++) begin
      int pv, qv, gv, cv, nv;
      pv = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 20);
      qv = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 20);
      gv = $urandom_range(1, 20);
      cv = $urandom_range(1, 4);
      nv = $urandom_range(1, 3);
      run_group(pv, qv, gv, cv, 4'($urandom_range(1, 15)), 4'($urandom_range(0, 15)),
                1'($urandom_range(0, 1)), nv, 1'($urandom_range(0, 1)));
      repeat ($urandom_range(1, 4)) tick;
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule